// File: doc/BRIEF.md
# Timer Tick Prescaler and Channel Divider

This block turns one base clock into five per-channel tick enables for a multi-channel PWM timer. Two 8-bit prescalers each serve a group of channels: the first serves channels 0 and 1, the second serves channels 2, 3 and 4. Each prescaler emits one enable every (value + 1) base cycles. Behind the prescalers, every channel has its own power-of-two divider. A 4-bit selection code per channel picks the division ratio, or hands the channel to an external clock input that belongs to its group.

The timer counters that consume these enables run in the base clock domain and advance only on cycles where their tick is high. No derived clock leaves the block. Both configuration words arrive as plain inputs. A prescaler picks up a new value only when it reaches its terminal count, so a period that is already running always finishes at its old length.

Top module: `tmr_tick_gen`

## Requirements
- R1: While `rst` is high, all bits of `tick_o` are 0. Reset clears every prescaler and divider counter to zero.
- R2: `pre_cfg_i[7:0]` sets the prescaler of group 0 (channels 0 and 1). `pre_cfg_i[15:8]` sets the prescaler of group 1 (channels 2, 3 and 4).
- R3: With prescaler value P and a channel division of 1, that channel ticks once every P+1 base cycles. P = 0 gives a tick on every cycle.
- R4: Channel c takes its selection code from `mux_cfg_i[4c+3:4c]`. For a code k that is not an external-clock code, the channel ticks every (P+1)·2^(k+DIV_BASE) base cycles. With DIV_BASE = 1, codes 0 to 3 give divisions of 2, 4, 8 and 16.
- R5: When k+DIV_BASE exceeds 4, the division is held at 16. With DIV_BASE = 1, code 7 divides by 16.
- R6: A code whose bit is set in EXT_MASK (code 4 by default) makes the channel follow an external clock. Channels 0 and 1 follow `ext_clk_i[0]`; channels 2 to 4 follow `ext_clk_i[1]`. After a two-flip-flop synchroniser, each rising edge of the selected input gives exactly one tick cycle. The external input of the other group has no effect on the channel.
- R7: If a prescaler field changes in a cycle that is not a terminal count of that prescaler, the new value takes effect only after the next terminal count. If the field changes in the terminal-count cycle itself, the new value takes effect right away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_clk_i | input | 2 | External clock inputs, one per channel group, asynchronous |
| pre_cfg_i | input | 16 | Prescaler values for group 0 (bits 7:0) and group 1 (bits 15:8) |
| mux_cfg_i | input | 20 | One 4-bit selection code per channel, channel c at bits 4c+3:4c |
| tick_o | output | 5 | Per-channel tick enables, one bit per channel |

## Verification
The case of interest is a write to a prescaler field that lands next to a terminal count of that prescaler. The bench watches a channel whose division is 2 and waits for it to tick, which also marks a terminal count. It then changes the prescaler from 9 to 2, once in that same cycle and once a cycle later. The expected gap to the next channel tick is 6 cycles for the first case and 13 for the second. A design that applies the new value at once, or one that ignores it until a later reload, gives a different gap.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    localparam int NUM_CH  = 5;
    localparam int NUM_GRP = 2;
    localparam int CODE_W  = 4;
    localparam int MAX_EXP = 4;
    localparam int DIV_W   = MAX_EXP;

    typedef struct packed {
        logic       use_ext;
        logic [2:0] shift;
    } ch_sel_t;

    // channels 0..1 belong to group 0, the rest to group 1
    function automatic int grp_of(input int ch);
        return (ch < 2) ? 0 : 1;
    endfunction

    function automatic ch_sel_t decode_code(input logic [CODE_W-1:0] code,
                                            input int base,
                                            input logic [15:0] ext_mask);
        ch_sel_t    s;
        logic [4:0] sum;
        sum       = 5'(code) + 5'(base);
        s.use_ext = ext_mask[code];
        s.shift   = (sum > 5'(MAX_EXP)) ? 3'(MAX_EXP) : sum[2:0];
        return s;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim_q;
    logic         term;

    assign term   = (cnt == lim_q);
    assign tick_o = !rst && term;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            lim_q <= '0;
        end else if (term) begin
            cnt   <= '0;
            lim_q <= limit_i;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim_q); // R3

    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(lim_q)); // R7

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic ext_i,
    output logic tick_o
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ext_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign tick_o = !rst && s2 && !s3;

    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R6

endmodule

// File: rtl/tmr_chan_div.sv
module tmr_chan_div #(
    parameter int CW = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_tick_i,
    input  logic [2:0] shift_i,
    output logic       tick_o
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;

    assign mask   = CW'((32'd1 << shift_i) - 32'd1);
    assign tick_o = pre_tick_i && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (pre_tick_i)
            cnt <= cnt + 1'b1;
    end

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
        !pre_tick_i |=> $stable(cnt)); // R4

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int          PRE_W    = 8,
    parameter int          DIV_BASE = 1,
    parameter logic [15:0] EXT_MASK = 16'h0010
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_GRP-1:0]         ext_clk_i,
    input  logic [NUM_GRP*PRE_W-1:0]   pre_cfg_i,
    input  logic [NUM_CH*CODE_W-1:0]   mux_cfg_i,
    output logic [NUM_CH-1:0]          tick_o
);
    logic [NUM_GRP-1:0] pre_tick;
    logic [NUM_GRP-1:0] ext_tick;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tmr_prescaler #(.W(PRE_W)) u_pre (
            .clk     (clk),
            .rst     (rst),
            .limit_i (pre_cfg_i[g*PRE_W +: PRE_W]),
            .tick_o  (pre_tick[g])
        );
        tmr_ext_sync u_ext (
            .clk    (clk),
            .rst    (rst),
            .ext_i  (ext_clk_i[g]),
            .tick_o (ext_tick[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = grp_of(c);
        ch_sel_t sel;
        logic    div_tick;

        assign sel = decode_code(mux_cfg_i[c*CODE_W +: CODE_W], DIV_BASE, EXT_MASK);

        tmr_chan_div #(.CW(DIV_W)) u_div (
            .clk        (clk),
            .rst        (rst),
            .pre_tick_i (pre_tick[G]),
            .shift_i    (sel.shift),
            .tick_o     (div_tick)
        );

        assign tick_o[c] = sel.use_ext ? ext_tick[G] : div_tick;
    end

endmodule

// File: tb/sim_tmr_tick_gen.sv
module sim_tmr_tick_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ext_clk = 2'b00;
    logic [15:0] pre_cfg = 16'h0;
    logic [19:0] mux_cfg = 20'h0;
    logic [4:0]  tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_tick_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .ext_clk_i (ext_clk),
        .pre_cfg_i (pre_cfg),
        .mux_cfg_i (mux_cfg),
        .tick_o    (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // steady-state interval check on all five channels
    task automatic run_sweep(input int p0, input int p1, input logic [19:0] mux, input string req);
        int last [5];
        int cnt  [5];
        int badv [5];
        pre_cfg = {p1[7:0], p0[7:0]};
        mux_cfg = mux;
        do_reset();
        for (int c = 0; c < 5; c++) begin
            last[c] = 0; cnt[c] = 0; badv[c] = -1;
        end
        for (int t = 0; t < 700; t++) begin
            @(negedge clk);
            for (int c = 0; c < 5; c++) begin
                if (tick[c]) begin
                    int code;
                    int e;
                    int p;
                    code = int'(mux[c*4 +: 4]);
                    e = (code + 1 > 4) ? 4 : code + 1;
                    p = (c < 2) ? p0 : p1;
                    if (cnt[c] >= 2 && (t - last[c]) != ((p + 1) << e) && badv[c] < 0)
                        badv[c] = t - last[c];
                    last[c] = t;
                    cnt[c]++;
                end
            end
        end
        for (int c = 0; c < 5; c++) begin
            int code;
            int e;
            int p;
            code = int'(mux[c*4 +: 4]);
            e = (code + 1 > 4) ? 4 : code + 1;
            p = (c < 2) ? p0 : p1;
            check(badv[c] < 0 && cnt[c] >= 4, req,
                  (badv[c] < 0) ? cnt[c] : badv[c], (p + 1) << e);
        end
    endtask

    task automatic run_ext(input int which);
        int last_a = 0;
        int cnt_a = 0;
        int cnt_b = 0;
        int badv = -1;
        int act_ch;
        int idle_ch;
        act_ch  = (which == 1) ? 2 : 0;
        idle_ch = (which == 1) ? 0 : 2;
        pre_cfg = 16'h0505;
        mux_cfg = 20'h00404;   // codes: ch0=4, ch2=4, others 0
        ext_clk = 2'b00;
        do_reset();
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (tick[act_ch]) begin
                if (cnt_a >= 1 && (t - last_a) != 10 && badv < 0) badv = t - last_a;
                last_a = t;
                cnt_a++;
            end
            if (tick[idle_ch]) cnt_b++;
            ext_clk[which] = ((t % 10) < 5);
        end
        ext_clk = 2'b00;
        check(badv < 0 && cnt_a >= 25, "R6 ext interval", (badv < 0) ? cnt_a : badv, 10);
        check(cnt_b == 0, "R6 other group idle", cnt_b, 0);
    endtask

    // R7: prescaler change relative to terminal count
    task automatic run_defer(input bit same_cycle, input int exp_gap);
        int gap;
        int seen;
        pre_cfg = 16'h0009;
        mux_cfg = 20'h00000;
        do_reset();
        seen = 0;
        while (seen < 2) begin
            @(negedge clk);
            if (tick[0]) seen++;
        end
        gap = 0;
        if (same_cycle) begin
            pre_cfg = 16'h0002;
        end else begin
            @(negedge clk);
            gap = 1;
            pre_cfg = 16'h0002;
        end
        do begin
            @(negedge clk);
            gap++;
        end while (!tick[0] && gap < 100);
        check(gap == exp_gap, same_cycle ? "R7 change at terminal" : "R7 change mid-period",
              gap, exp_gap);
    endtask

    initial begin
        // R1: reset holds ticks low even with prescalers at zero
        pre_cfg = 16'h0000;
        mux_cfg = 20'h00000;
        repeat (4) @(negedge clk);
        check(tick == 5'b0, "R1 reset quiet", int'(tick), 0);

        // R2 R3 R4: sweep prescaler pairs and uniform codes 0..3
        for (int pi = 0; pi < 3; pi++) begin
            int p0;
            int p1;
            p0 = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
            p1 = (pi == 0) ? 2 : (pi == 1) ? 0 : 4;
            for (int k = 0; k < 4; k++) begin
                logic [19:0] m;
                m = {5{4'(k)}};
                run_sweep(p0, p1, m, "R2 R3 R4 uniform code");
            end
            // R5: mixed codes, ch4 uses code 7 which clamps to 16
            run_sweep(p0, p1, 20'h73210, "R4 R5 mixed codes");
        end

        run_ext(0);
        run_ext(1);

        run_defer(1'b1, 6);
        run_defer(1'b0, 13);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule